// File: doc/BRIEF.md
# Byte-Addressed GPIO Register Driving an Open-Drain Two-Wire Bus

This block holds a 24-bit general-purpose I/O register. The host reaches it one byte at a time through a plain register port: a two-bit byte address, a write strobe, write data and combinational read data. The register has three bytes. One is an output byte, one is a direction byte and one is an input byte that software can only read. Bit 0 and bit 1 of the output and direction bytes steer the data and clock lines of an open-drain two-wire bus such as I2C or SMBus. Software toggles these bits to bit-bang the bus protocol.

A write only acts when it changes the stored byte. When it does, the new byte is stored and the bus drive is re-evaluated. The input byte is then rebuilt: all bits are cleared and the sampled data-line level is placed in bit 0. The data line follows the register at all times. The clock line is updated only by a changing write that leaves the clock direction bit set; otherwise it keeps its previous drive.

Each line is modelled as open-drain. The block either pulls the line low or releases it. The level it senses is the wired-AND of its own drive and an external pull-down input.

Top module: `gpio_i2c_bitbang`

## Requirements
- R1: After reset all 24 register bits read 0 and both lines are released (`sda_pull_low` = 0, `scl_pull_low` = 0).
- R2: A read at byte address 0, 1 or 2 returns the input, output or direction byte respectively; a read at address 3 returns 0x00.
- R3: A write to address 0 (the input byte) or to address 3 changes no register bit and no line drive.
- R4: A write to address 1 or 2 whose data equals the byte already stored there has no effect: every byte, including the input byte, keeps its value even if the external line levels have changed.
- R5: A write to address 1 or 2 with data different from the stored byte stores the new byte, visible on a read from the next cycle.
- R6: After a changing write, input byte bits 7..1 read 0 and bit 0 holds the data-line level sensed in the write cycle, using the new drive and the external pull-down: level = 1 only if neither pulls low.
- R7: `sda_pull_low` is 1 exactly when direction bit 0 (address 2) is 1 and output bit 0 (address 1) is 0; otherwise the data line is released.
- R8: On a changing write after which direction bit 1 is 1, `scl_pull_low` becomes the inverse of output bit 1. On a changing write that leaves direction bit 1 at 0, `scl_pull_low` keeps its previous value.
- R9: Outside changing writes the input byte holds its value; changes on the external pull-down inputs alone do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 2 | Byte address (0 input, 1 output, 2 direction, 3 unused) |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data for the byte at `addr` (combinational) |
| sda_ext_low | input | 1 | External device pulls the data line low |
| scl_ext_low | input | 1 | External device pulls the clock line low |
| sda_pull_low | output | 1 | This block pulls the data line low |
| scl_pull_low | output | 1 | This block pulls the clock line low |

## Verification
Random byte writes draw their data from a small set of values, so that unchanged writes (R4) occur often next to changing ones. This separates the change-detect rule from plain storage. The external pull-down inputs are also randomised, including between writes. This shows whether the input byte is sampled only at a changing write (R9) and whether the sensed level combines the new drive with the outside pull-down (R6). Directed sequences set and clear direction bit 1 around output changes. These separate the clock line's hold behaviour (R8) from the data line, which always follows the register (R7). Writes to the read-only and unused addresses are also directed and checked (R3).

// File: rtl/gpio_i2c_pkg.sv
package gpio_i2c_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned SDA_BIT = 0;
  localparam int unsigned SCL_BIT = 1;
  localparam int unsigned N_LINES = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_IN   = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_NONE = 2'd3
  } byte_sel_e;

  // open-drain: drive low when enabled as output with value 0
  function automatic logic od_pull(input logic dir_bit, input logic out_bit);
    return dir_bit & ~out_bit;
  endfunction

  // wired-AND of own drive and the external pull-down
  function automatic logic wired_level(input logic own_low, input logic ext_low);
    return ~(own_low | ext_low);
  endfunction
endpackage

// File: rtl/gpio_i2c_line.sv
module gpio_i2c_line
  import gpio_i2c_pkg::*;
(
  input  logic dir_bit,
  input  logic out_bit,
  input  logic ext_low,
  output logic pull_low,
  output logic level
);
  always_comb begin
    pull_low = od_pull(dir_bit, out_bit);
    level    = wired_level(pull_low, ext_low);
  end
endmodule

// File: rtl/gpio_i2c_regfile.sv
module gpio_i2c_regfile
  import gpio_i2c_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  input  logic          sda_level_nxt,
  output logic [DW-1:0] in_q,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] out_nxt,
  output logic [DW-1:0] dir_nxt,
  output logic          commit,
  output logic [DW-1:0] rd_data
);
  byte_sel_e     sel;
  logic [DW-1:0] cur_byte;
  logic          writable;
  logic [DW-1:0] in_nxt;

  assign sel = byte_sel_e'(addr);

  always_comb begin
    unique case (sel)
      SEL_IN:  cur_byte = in_q;
      SEL_OUT: cur_byte = out_q;
      SEL_DIR: cur_byte = dir_q;
      default: cur_byte = '0;
    endcase
  end

  assign rd_data  = cur_byte;
  assign writable = wr_en && (sel == SEL_OUT || sel == SEL_DIR);
  assign commit   = writable && (wr_data != cur_byte);

  always_comb begin
    out_nxt = out_q;
    dir_nxt = dir_q;
    in_nxt  = in_q;
    if (commit) begin
      if (sel == SEL_OUT) out_nxt = wr_data;
      else                dir_nxt = wr_data;
      in_nxt = {{(DW-1){1'b0}}, sda_level_nxt};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      out_q <= '0;
      dir_q <= '0;
    end else begin
      in_q  <= in_nxt;
      out_q <= out_nxt;
      dir_q <= dir_nxt;
    end
  end

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({in_q, out_q, dir_q})); // R4
  AST_RO_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == SEL_IN || addr == SEL_NONE)) |=> $stable({in_q, out_q, dir_q})); // R3
  AST_OUT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr == SEL_OUT) |=> out_q == $past(wr_data)); // R5
  AST_DIR_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr == SEL_DIR) |=> dir_q == $past(wr_data)); // R5
  AST_IN_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    in_q[DW-1:1] == '0); // R6
  AST_IN_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> in_q[0] == $past(sda_level_nxt)); // R6
endmodule

// File: rtl/gpio_i2c_bitbang.sv
module gpio_i2c_bitbang
  import gpio_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              sda_ext_low,
  input  logic              scl_ext_low,
  output logic              sda_pull_low,
  output logic              scl_pull_low
);
  logic [BYTE_W-1:0]  in_q, out_q, dir_q, out_nxt, dir_nxt;
  logic               commit;
  logic [N_LINES-1:0] ext_low;
  logic [N_LINES-1:0] nxt_pull, nxt_level;
  logic               scl_low_q;

  assign ext_low[SDA_BIT] = sda_ext_low;
  assign ext_low[SCL_BIT] = scl_ext_low;

  // line evaluation on next-state register values (level after the update)
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    gpio_i2c_line u_line (
      .dir_bit  (dir_nxt[g]),
      .out_bit  (out_nxt[g]),
      .ext_low  (ext_low[g]),
      .pull_low (nxt_pull[g]),
      .level    (nxt_level[g])
    );
  end

  gpio_i2c_regfile u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .addr          (addr),
    .wr_data       (wr_data),
    .sda_level_nxt (nxt_level[SDA_BIT]),
    .in_q          (in_q),
    .out_q         (out_q),
    .dir_q         (dir_q),
    .out_nxt       (out_nxt),
    .dir_nxt       (dir_nxt),
    .commit        (commit),
    .rd_data       (rd_data)
  );

  // clock drive is re-evaluated only by a changing write with its direction set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         scl_low_q <= 1'b0;
    else if (commit && dir_nxt[SCL_BIT]) scl_low_q <= nxt_pull[SCL_BIT];
  end

  assign sda_pull_low = od_pull(dir_q[SDA_BIT], out_q[SDA_BIT]);
  assign scl_pull_low = scl_low_q;

  AST_SCL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !dir_nxt[SCL_BIT]) |=> $stable(scl_pull_low)); // R8
  AST_SCL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && dir_nxt[SCL_BIT]) |=> scl_pull_low == !out_q[SCL_BIT]); // R8
  AST_SCL_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(scl_pull_low)); // R8
  AST_SDA_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_q[SDA_BIT] |-> !sda_pull_low); // R7
endmodule

// File: tb/gpio_i2c_bitbang_bench.sv
module gpio_i2c_bitbang_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       sda_ext_low = 1'b0;
  logic       scl_ext_low = 1'b0;
  logic       sda_pull_low, scl_pull_low;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_in, m_out, m_dir;
  logic       m_scl;

  always #2.5 clk = ~clk;

  gpio_i2c_bitbang u_gpio_i2c_bitbang (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .sda_ext_low(sda_ext_low), .scl_ext_low(scl_ext_low),
    .sda_pull_low(sda_pull_low), .scl_pull_low(scl_pull_low)
  );

  function automatic logic exp_sda_low(input logic [7:0] d, input logic [7:0] o);
    return (d[0] == 1'b1) && (o[0] == 1'b0);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic read_byte(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic check_all(input string tag);
    logic [7:0] v;
    read_byte(2'd0, v); check({tag, " in"}, v, m_in);
    read_byte(2'd1, v); check({tag, " out"}, v, m_out);
    read_byte(2'd2, v); check({tag, " dir"}, v, m_dir);
    read_byte(2'd3, v); check({tag, " R2 addr3"}, v, 8'h00);
    check({tag, " R7 sda"}, {7'd0, sda_pull_low}, {7'd0, exp_sda_low(m_dir, m_out)});
    check({tag, " R8 scl"}, {7'd0, scl_pull_low}, {7'd0, m_scl});
  endtask

  // model update for a write performed while external inputs hold their values
  task automatic model_write(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] cur;
    if (a == 2'd1 || a == 2'd2) begin
      cur = (a == 2'd1) ? m_out : m_dir;
      if (d != cur) begin
        if (a == 2'd1) m_out = d; else m_dir = d;
        m_in = {7'd0, !(exp_sda_low(m_dir, m_out) || sda_ext_low)};
        if (m_dir[1]) m_scl = !m_out[1];
      end
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    m_in = 0; m_out = 0; m_dir = 0; m_scl = 0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");

    // R5/R7: drive data low, then release by direction
    do_write(2'd2, 8'h01);
    do_write(2'd1, 8'h00);
    check_all("R5 R7 sda low");
    check({"R6 in"}, m_in, 8'h00);
    do_write(2'd1, 8'h01);
    check_all("R7 sda high");

    // R3: writes to input byte and unused address ignored
    do_write(2'd0, 8'hA5);
    do_write(2'd3, 8'h5A);
    check_all("R3 ignored");

    // R6: external pull-down seen by the sample
    sda_ext_low = 1'b1;
    do_write(2'd1, 8'hF1);
    check_all("R6 ext low");
    read_byte(2'd0, v); check("R6 bit0 zero", v, 8'h00);

    // R9 and R4: external change alone, then equal write
    sda_ext_low = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R9 hold");
    do_write(2'd1, 8'hF1);
    read_byte(2'd0, v); check("R4 equal write in", v, 8'h00);
    check_all("R4 equal write");

    // R8: clock hold while direction bit 1 is 0, follow once set
    do_write(2'd1, 8'h00);
    check_all("R8 hold dir0");
    do_write(2'd2, 8'h03);
    check_all("R8 follow low");
    check("R8 scl pulled", {7'd0, scl_pull_low}, 8'h01);
    do_write(2'd1, 8'h02);
    check_all("R8 follow high");
    do_write(2'd1, 8'h00);
    do_write(2'd2, 8'h01);
    do_write(2'd1, 8'h02);
    check("R8 hold after clear", {7'd0, scl_pull_low}, 8'h01);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom_range(0, 3)) | (($urandom_range(0, 7) == 0) ? 8'h80 : 8'h00);
      sda_ext_low = 1'($urandom_range(0, 1));
      scl_ext_low = 1'($urandom_range(0, 1));
      do_write(a, d);
      if (i % 4 == 0) begin
        sda_ext_low = ~sda_ext_low;
        check_all("R4 R5 R6 R9 random");
      end else begin
        read_byte(2'd0, v); check("R6 R9 random in", v, m_in);
        check("R7 random sda", {7'd0, sda_pull_low}, {7'd0, exp_sda_low(m_dir, m_out)});
        check("R8 random scl", {7'd0, scl_pull_low}, {7'd0, m_scl});
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule